// File: doc/BRIEF.md
# Bus Address Page Map Translator

This block turns an 18-bit byte address from a peripheral bus into a word address in a memory built from 36-bit words. Each memory word holds four bus bytes. The two lowest address bits pick the byte lane inside the word. The next nine bits give the word offset inside a 512-word page. The six bits above those pick one of 64 page map entries. Each entry holds a valid flag and a page base word address. The physical word address is the page base plus the word offset, and the sum wraps at the physical address width.

A lookup is a one-cycle registered operation. A request strobe carries the address in, and one clock later a response strobe carries one of three outcomes:
- a mapped physical address and its lane,
- a fault,
- a device-space indication.

The upper address half (bit 17 set) never reaches memory. Inside it, the top region from 0760000 to 0777777 octal is device register space and passes around the map without any fault. Every other address in the upper half faults, and so does any address whose map entry is not valid. A fault sets a sticky timeout bit in the status register, and software clears that bit by writing a 1 to it. The map entries and the status register share one register write port.

Top module: `bus_page_map`

## Requirements
- R1: After a synchronous active-low reset, `rsp_vld` and `timeout` are 0 and every map entry is invalid, so a lookup in the lower address half faults.
- R2: `rsp_vld` is high in exactly the cycle after a cycle in which `lk_req` was high, and low otherwise.
- R3: A lookup of address A whose entry A[16:11] is valid returns `rsp_ok`=1, `rsp_fault`=0, `rsp_dev`=0, `rsp_lane`=A[1:0] and `rsp_pa`=(base + A[10:2]) modulo 2^PA_W.
- R4: The entry used is the one whose index equals A[16:11], and entries with other indices have no effect on the result.
- R5: A lookup in the lower half whose entry is invalid returns `rsp_fault`=1, `rsp_ok`=0 and `rsp_pa`=0.
- R6: A lookup with A[17]=1 and A below 0760000 octal returns `rsp_fault`=1, whatever the map holds.
- R7: A lookup with A[17:13] all ones returns `rsp_dev`=1, `rsp_ok`=0, `rsp_fault`=0, `rsp_pa`=0, and leaves `timeout` unchanged.
- R8: A faulting lookup sets `timeout` on the edge that registers the response, and the bit stays set through later lookups that do not fault.
- R9: A write with `cfg_is_stat`=1 and `cfg_wdata[0]`=1 clears `timeout`. With `cfg_wdata[0]`=0 the write leaves `timeout` unchanged. When a fault arrives in the same cycle as a clear, `timeout` ends up set.
- R10: A map write with `cfg_is_stat`=0 stores `cfg_wdata[PA_W]` as the valid flag and `cfg_wdata[PA_W-1:0]` as the base at index `cfg_idx`. A lookup in the same cycle to that index sees the old contents, and the next lookup sees the new contents.
- R11: A map write with the valid flag at 0 makes the next lookup through that entry fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_is_stat | input | 1 | 1 writes the status register, 0 writes a map entry |
| cfg_idx | input | 6 | Map entry index for map writes |
| cfg_wdata | input | PA_W+1 (23) | Map write: {valid, base}. Status write: bit 0 = clear timeout |
| lk_req | input | 1 | Lookup request strobe |
| lk_addr | input | 18 | Bus byte address to translate |
| rsp_vld | output | 1 | Response strobe, one cycle after `lk_req` |
| rsp_pa | output | PA_W (22) | Physical word address, 0 unless mapped |
| rsp_lane | output | 2 | Byte lane within the word |
| rsp_ok | output | 1 | Address mapped to memory |
| rsp_fault | output | 1 | Lookup failed |
| rsp_dev | output | 1 | Address lies in device register space |
| timeout | output | 1 | Sticky timeout status bit |

## Verification
Every lookup result, and the timeout update it causes, becomes visible after the clock edge that follows the request cycle. The bench therefore applies each request, map write and status write just after one edge and samples all outputs one time unit after the next edge. A cycle with no request is checked the same way and must show `rsp_vld` low. Map writes, status writes and lookups can share a cycle, so the reference model works out the response from the map contents as they stood before the write, and computes the timeout bit with a set that wins over a clear.

// File: rtl/bpm_pkg.sv
// Package: shared types for the bus page map translator.
// Assumes nothing beyond the parameters passed to the modules.
package bpm_pkg;

    // Outcome of one lookup
    typedef enum logic [1:0] {
        KIND_MAPPED = 2'd0,
        KIND_FAULT  = 2'd1,
        KIND_DEVICE = 2'd2
    } lk_kind_e;

endpackage

// File: rtl/bpm_addr_split.sv
// Module: splits a bus byte address into lane, word offset and map index,
// and classifies it as lower half, device space or upper-half fault.
// Assumes ADDR_W = LANE_W + OFFS_W + IDX_W + 1 (one top half-select bit).
module bpm_addr_split #(
    parameter int ADDR_W  = 18,
    parameter int LANE_W  = 2,
    parameter int OFFS_W  = 9,
    parameter int IDX_W   = 6,
    parameter int DEV_W   = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [LANE_W-1:0] lane,
    output logic [OFFS_W-1:0] offs,
    output logic [IDX_W-1:0]  idx,
    output logic              upper_half,
    output logic              dev_space
);
    localparam int OFFS_LO = LANE_W;
    localparam int IDX_LO  = LANE_W + OFFS_W;

    // Field extraction and region decode
    always_comb begin
        lane       = addr[LANE_W-1:0];
        offs       = addr[OFFS_LO +: OFFS_W];
        idx        = addr[IDX_LO +: IDX_W];
        upper_half = addr[ADDR_W-1];
        dev_space  = &addr[ADDR_W-1 -: DEV_W];
    end
endmodule

// File: rtl/bpm_map_table.sv
// Module: page map entry storage, one valid flag and one base per entry.
// One write port, one asynchronous read port. A read in the write cycle
// returns the old contents. Reset clears every valid flag.
module bpm_map_table #(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = 6,
    parameter int BASE_W  = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic              wvalid,
    input  logic [BASE_W-1:0] wbase,
    input  logic [IDX_W-1:0]  ridx,
    output logic              rvalid,
    output logic [BASE_W-1:0] rbase
);
    logic              ent_v [ENTRIES];
    logic [BASE_W-1:0] ent_b [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        // Entry register: cleared to invalid on reset, loaded on a matching write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_v[g] <= 1'b0;
                ent_b[g] <= '0;
            end else if (we && (widx == IDX_W'(g))) begin
                ent_v[g] <= wvalid;
                ent_b[g] <= wbase;
            end
        end
    end

    // Read port
    always_comb begin
        rvalid = ent_v[ridx];
        rbase  = ent_b[ridx];
    end
endmodule

// File: rtl/bpm_status.sv
// Module: sticky timeout status bit. A fault sets it, a write-one clears it,
// and a set wins over a clear in the same cycle.
module bpm_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic to_o
);
    // Sticky bit update
    always_ff @(posedge clk) begin
        if (!rst_n)      to_o <= 1'b0;
        else if (set_i)  to_o <= 1'b1;
        else if (clr_i)  to_o <= 1'b0;
    end
endmodule

// File: rtl/bus_page_map.sv
// Module: top of the bus page map translator. Decodes the request address,
// looks up the map entry, forms the physical word address and registers
// the response one cycle after the request. Faults set the sticky timeout.
// Assumes lk_req is a single-cycle strobe per lookup (back-to-back allowed).
module bus_page_map
    import bpm_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int LANE_W = 2,
    parameter int OFFS_W = 9,
    parameter int PA_W   = 22,
    parameter int DEV_W  = 5,
    localparam int IDX_W   = ADDR_W - 1 - LANE_W - OFFS_W,
    localparam int ENTRIES = 1 << IDX_W,
    localparam int CFG_W   = PA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_is_stat,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              lk_req,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              rsp_vld,
    output logic [PA_W-1:0]   rsp_pa,
    output logic [LANE_W-1:0] rsp_lane,
    output logic              rsp_ok,
    output logic              rsp_fault,
    output logic              rsp_dev,
    output logic              timeout
);
    logic [LANE_W-1:0] a_lane;
    logic [OFFS_W-1:0] a_offs;
    logic [IDX_W-1:0]  a_idx;
    logic              a_upper;
    logic              a_dev;
    logic              m_valid;
    logic [PA_W-1:0]   m_base;
    lk_kind_e          kind_d;
    lk_kind_e          kind_q;
    logic [PA_W-1:0]   pa_d;
    logic              fault_now;
    logic              stat_clr;

    bpm_addr_split #(
        .ADDR_W (ADDR_W),
        .LANE_W (LANE_W),
        .OFFS_W (OFFS_W),
        .IDX_W  (IDX_W),
        .DEV_W  (DEV_W)
    ) u_split (
        .addr       (lk_addr),
        .lane       (a_lane),
        .offs       (a_offs),
        .idx        (a_idx),
        .upper_half (a_upper),
        .dev_space  (a_dev)
    );

    bpm_map_table #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W),
        .BASE_W  (PA_W)
    ) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we && !cfg_is_stat),
        .widx   (cfg_idx),
        .wvalid (cfg_wdata[PA_W]),
        .wbase  (cfg_wdata[PA_W-1:0]),
        .ridx   (a_idx),
        .rvalid (m_valid),
        .rbase  (m_base)
    );

    // Classify the lookup and form the physical word address
    always_comb begin
        pa_d = '0;
        if (a_dev) begin
            kind_d = KIND_DEVICE;
        end else if (a_upper || !m_valid) begin
            kind_d = KIND_FAULT;
        end else begin
            kind_d = KIND_MAPPED;
            pa_d   = m_base + PA_W'(a_offs);
        end
    end

    assign fault_now = lk_req && (kind_d == KIND_FAULT);
    assign stat_clr  = cfg_we && cfg_is_stat && cfg_wdata[0];

    bpm_status u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (fault_now),
        .clr_i (stat_clr),
        .to_o  (timeout)
    );

    // Response register: captures the result on each request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld  <= 1'b0;
            kind_q   <= KIND_FAULT;
            rsp_pa   <= '0;
            rsp_lane <= '0;
        end else begin
            rsp_vld <= lk_req;
            if (lk_req) begin
                kind_q   <= kind_d;
                rsp_pa   <= pa_d;
                rsp_lane <= a_lane;
            end
        end
    end

    // Decode the registered outcome into strobes qualified by rsp_vld
    always_comb begin
        rsp_ok    = rsp_vld && (kind_q == KIND_MAPPED);
        rsp_fault = rsp_vld && (kind_q == KIND_FAULT);
        rsp_dev   = rsp_vld && (kind_q == KIND_DEVICE);
    end
endmodule

// File: rtl/bus_page_map_chk.sv
// Checker: temporal properties of the translator, attached by bind.
// Assumes the same parameters as the top module.
module bus_page_map_chk #(
    parameter int ADDR_W = 18,
    parameter int LANE_W = 2,
    parameter int PA_W   = 22,
    parameter int DEV_W  = 5,
    parameter int IDX_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              cfg_is_stat,
    input logic [PA_W:0]     cfg_wdata,
    input logic              lk_req,
    input logic [ADDR_W-1:0] lk_addr,
    input logic              rsp_vld,
    input logic [PA_W-1:0]   rsp_pa,
    input logic [LANE_W-1:0] rsp_lane,
    input logic              rsp_ok,
    input logic              rsp_fault,
    input logic              rsp_dev,
    input logic              timeout
);
    logic armed;

    // Marks the cycles after the first edge out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    AST_REQ_GIVES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_vld);  // R2
    AST_RSP_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        armed && rsp_vld |-> $past(lk_req));  // R2
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld |-> $countones({rsp_ok, rsp_fault, rsp_dev}) == 1);  // R3
    AST_NO_OUTCOME_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_vld |-> !(rsp_ok || rsp_fault || rsp_dev));  // R2
    AST_LANE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        armed && rsp_vld |-> rsp_lane == $past(lk_addr[LANE_W-1:0]));  // R3
    AST_UPPER_NOT_MAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        armed && rsp_vld && $past(lk_addr[ADDR_W-1]) |-> !rsp_ok);  // R6
    AST_DEV_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        armed && rsp_dev |-> (&$past(lk_addr[ADDR_W-1 -: DEV_W])) && rsp_pa == '0);  // R7
    AST_FAULT_SETS_TO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> timeout);  // R8
    AST_TO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(timeout) && !$past(cfg_we && cfg_is_stat && cfg_wdata[0]) |-> timeout);  // R8
    AST_TO_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(cfg_we && cfg_is_stat && cfg_wdata[0]) && !rsp_fault |-> !timeout);  // R9
endmodule

bind bus_page_map bus_page_map_chk #(
    .ADDR_W (ADDR_W),
    .LANE_W (LANE_W),
    .PA_W   (PA_W),
    .DEV_W  (DEV_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_is_stat (cfg_is_stat),
    .cfg_wdata   (cfg_wdata),
    .lk_req      (lk_req),
    .lk_addr     (lk_addr),
    .rsp_vld     (rsp_vld),
    .rsp_pa      (rsp_pa),
    .rsp_lane    (rsp_lane),
    .rsp_ok      (rsp_ok),
    .rsp_fault   (rsp_fault),
    .rsp_dev     (rsp_dev),
    .timeout     (timeout)
);

// File: tb/bus_page_map_tb.sv
// Bench: directed corners plus seeded random traffic against a reference model.
module bus_page_map_tb;
    localparam int ADDR_W = 18;
    localparam int PA_W   = 22;
    localparam int IDX_W  = 6;
    localparam int NENT   = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic              cfg_is_stat = 1'b0;
    logic [IDX_W-1:0]  cfg_idx = '0;
    logic [PA_W:0]     cfg_wdata = '0;
    logic              lk_req = 1'b0;
    logic [ADDR_W-1:0] lk_addr = '0;
    logic              rsp_vld;
    logic [PA_W-1:0]   rsp_pa;
    logic [1:0]        rsp_lane;
    logic              rsp_ok;
    logic              rsp_fault;
    logic              rsp_dev;
    logic              timeout;

    int checks = 0;
    int errors = 0;
    logic            mdl_v [NENT];
    logic [PA_W-1:0] mdl_b [NENT];
    logic            mdl_to;

    always #5 clk = ~clk;

    bus_page_map u_dut (
        .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_is_stat (cfg_is_stat),
        .cfg_idx (cfg_idx), .cfg_wdata (cfg_wdata), .lk_req (lk_req), .lk_addr (lk_addr),
        .rsp_vld (rsp_vld), .rsp_pa (rsp_pa), .rsp_lane (rsp_lane), .rsp_ok (rsp_ok),
        .rsp_fault (rsp_fault), .rsp_dev (rsp_dev), .timeout (timeout)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected outcome: 0 mapped, 1 fault, 2 device
    function automatic int exp_kind(input logic [ADDR_W-1:0] a);
        if (&a[17:13]) return 2;
        if (a[17] || !mdl_v[a[16:11]]) return 1;
        return 0;
    endfunction

    function automatic logic [PA_W-1:0] exp_pa(input logic [ADDR_W-1:0] a);
        if (exp_kind(a) != 0) return '0;
        return mdl_b[a[16:11]] + PA_W'(a[10:2]);
    endfunction

    // One clock with optional write and lookup, then check at edge+1
    task automatic cyc(input logic we, input logic st, input logic [IDX_W-1:0] idx,
                       input logic [PA_W:0] wd, input logic rq,
                       input logic [ADDR_W-1:0] a, input string tag);
        int k;
        logic [PA_W-1:0] p;
        logic nto;
        k = exp_kind(a);
        p = exp_pa(a);
        nto = mdl_to;
        if (we && st && wd[0]) nto = 1'b0;
        if (rq && k == 1) nto = 1'b1;
        cfg_we = we; cfg_is_stat = st; cfg_idx = idx; cfg_wdata = wd;
        lk_req = rq; lk_addr = a;
        @(posedge clk);
        #1;
        cfg_we = 1'b0; lk_req = 1'b0;
        if (we && !st) begin
            mdl_v[idx] = wd[PA_W];
            mdl_b[idx] = wd[PA_W-1:0];
        end
        mdl_to = nto;
        chk({tag, " R2 rsp_vld"}, 32'(rsp_vld), 32'(rq));
        if (rq) begin
            chk({tag, " R3 ok"}, 32'(rsp_ok), 32'(k == 0));
            chk({tag, " R5 fault"}, 32'(rsp_fault), 32'(k == 1));
            chk({tag, " R7 dev"}, 32'(rsp_dev), 32'(k == 2));
            chk({tag, " R4 pa"}, 32'(rsp_pa), 32'(p));
            chk({tag, " R3 lane"}, 32'(rsp_lane), 32'(a[1:0]));
        end
        chk({tag, " R8 timeout"}, 32'(timeout), 32'(nto));
    endtask

    task automatic mapw(input int i, input logic v, input logic [PA_W-1:0] b);
        cyc(1'b1, 1'b0, IDX_W'(i), {v, b}, 1'b0, '0, "R10 mapwrite");
    endtask

    task automatic look(input logic [ADDR_W-1:0] a, input string tag);
        cyc(1'b0, 1'b0, '0, '0, 1'b1, a, tag);
    endtask

    initial begin : watchdog
        #1000000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        for (int i = 0; i < NENT; i++) begin mdl_v[i] = 1'b0; mdl_b[i] = '0; end
        mdl_to = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk("R1 rsp_vld after reset", 32'(rsp_vld), 32'd0);
        chk("R1 timeout after reset", 32'(timeout), 32'd0);
        look(18'o000123, "R1 lookup after reset faults");
        cyc(1'b1, 1'b1, '0, 23'd1, 1'b0, '0, "R9 clear");
        // R3 R4 mapped lookups with wrap
        mapw(5, 1'b1, 22'h000400);
        mapw(6, 1'b1, 22'h3FFFF0);
        look({1'b0, 6'd5, 9'd0, 2'd0}, "R3 base");
        look({1'b0, 6'd5, 9'h1FF, 2'd3}, "R3 last word lane3");
        look({1'b0, 6'd6, 9'd20, 2'd1}, "R3 wrap");
        look({1'b0, 6'd4, 9'd3, 2'd0}, "R4 neighbour invalid");
        chk("R8 sticky", 32'(timeout), 32'd1);
        look({1'b0, 6'd5, 9'd7, 2'd2}, "R8 stays after good lookup");
        // R9 write with bit0 clear does nothing, then clear, then set wins
        cyc(1'b1, 1'b1, '0, 23'd2, 1'b0, '0, "R9 no clear");
        cyc(1'b1, 1'b1, '0, 23'd1, 1'b0, '0, "R9 clear");
        cyc(1'b1, 1'b1, '0, 23'd1, 1'b1, {1'b0, 6'd9, 11'd0}, "R9 set wins");
        cyc(1'b1, 1'b1, '0, 23'd1, 1'b0, '0, "R9 clear again");
        // R6 upper half faults even with map valid; R7 device space
        mapw(0, 1'b1, 22'h001000);
        look(18'o400000, "R6 upper half");
        look(18'o757777, "R6 just below device");
        cyc(1'b1, 1'b1, '0, 23'd1, 1'b0, '0, "R9 clear");
        look(18'o760000, "R7 device low");
        look(18'o777777, "R7 device high");
        // R10 write and lookup same cycle same index
        cyc(1'b1, 1'b0, 6'd12, {1'b1, 22'h012345}, 1'b1, {1'b0, 6'd12, 9'd1, 2'd0}, "R10 same cycle");
        look({1'b0, 6'd12, 9'd1, 2'd0}, "R10 next");
        // R11 invalidate
        mapw(12, 1'b0, 22'h0);
        look({1'b0, 6'd12, 9'd1, 2'd0}, "R11 invalidated");
        // Random traffic
        for (int n = 0; n < 600; n++) begin
            logic we, st, rq;
            logic [ADDR_W-1:0] a;
            logic [PA_W:0] wd;
            we = ($urandom % 3) == 0;
            st = ($urandom % 6) == 0;
            rq = ($urandom % 4) != 0;
            wd = (PA_W+1)'($urandom);
            a = ADDR_W'($urandom);
            if (($urandom % 3) != 0) a[17] = 1'b0;
            cyc(we, st, IDX_W'($urandom), wd, rq, a, "R3 random");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule